// File: doc/BRIEF.md
# Tri-State Phase Detector with Pump Control

This block sits between the two frequency dividers of a synthesizer loop and the analog charge pump. Both divider outputs are sampled in the system clock domain, and only their rising edges are used. A reference edge raises the UP command and a feedback edge raises the DOWN command. When both commands are high, they are held together for a short fixed overlap and then cleared together. Because the overlap is always present, small phase errors still yield a pump pulse and the detector has no dead zone. In the quiet state neither command is active, which is the high-impedance state of the pump.

A single two-bit mode input drives all of the pump-side controls at once:

- In the two normal modes it enables the pump and picks the small or the large current.
- In the third mode it switches the pump off and routes the feedback divider to a test monitor pin.
- In the fourth mode it clamps the loop-filter amplifier input to ground, keeps the pump off, and routes the reference divider to the monitor.

While the pump is off, the UP and DOWN outputs are held low, but the edge state machine keeps running. Every pin is a plain level. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: After reset, pump_up_o, pump_dn_o and tmon_o are 0.
- R2: A rising edge on ref_div_i raises pump_up_o two clock edges after the input is sampled high. pump_up_o stays high until the overlap-clear described in R4.
- R3: A rising edge on fb_div_i raises pump_dn_o with the same two-edge latency.
- R4: Once UP and DOWN are both set, both stay high for exactly RST_DLY cycles and then clear in the same cycle. The default RST_DLY is 2.
- R5: If a new divider edge falls in the cycle in which the overlap clears, the matching command is set rather than cleared, so that edge is not lost.
- R6: Mode code 2'b00 gives pump_en_o=1 and cur_hi_o=0. Mode code 2'b10 gives pump_en_o=1 and cur_hi_o=1.
- R7: Mode code 2'b01 forces pump_en_o, pump_up_o and pump_dn_o to 0. It sets tmon_oe_o=1, and tmon_o then follows fb_div_i one edge late.
- R8: Mode code 2'b11 sets filt_clamp_o=1 and forces the pump off. It sets tmon_oe_o=1, and tmon_o then follows ref_div_i one edge late.
- R9: In mode codes 2'b00 and 2'b10, tmon_oe_o=0 and tmon_o=0. filt_clamp_o is 1 only in mode code 2'b11.
- R10: Edges that arrive while the pump is off still set the internal commands. These commands appear on the pump outputs as soon as a pumping mode returns.
- R11: A divider input held high does not set a command again after it has been cleared. Only rising edges count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_div_i | input | 1 | Reference divider output |
| fb_div_i | input | 1 | Feedback divider output |
| mode_i | input | 2 | Mode code: 00 low current, 01 off/monitor feedback, 10 high current, 11 clamp/monitor reference |
| pump_up_o | output | 1 | Source-current command |
| pump_dn_o | output | 1 | Sink-current command |
| pump_en_o | output | 1 | Charge pump enable |
| cur_hi_o | output | 1 | Selects the larger pump current |
| filt_clamp_o | output | 1 | Ties the filter amplifier input to ground |
| tmon_o | output | 1 | Test monitor signal |
| tmon_oe_o | output | 1 | Test monitor drive enable |

## Verification
Two functions can fall in the same cycle: the overlap-clear of both commands, and the capture of a fresh reference edge. The bench provokes this by dropping the reference input and raising it again, so that its sampled edge lands exactly in the clearing cycle of an overlap. It then expects UP to stay high while DOWN falls. A second case captures a feedback edge while the pump is off. The bench expects that command to show up on the cycle the mode returns to pumping.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    MODE_LO   = 2'b00,
    MODE_MID  = 2'b01,
    MODE_HI   = 2'b10,
    MODE_OPEN = 2'b11
  } pfd_mode_e;

  typedef struct packed {
    logic pump_en;
    logic cur_hi;
    logic clamp;
    logic mon_oe;
    logic mon_fb;
  } pfd_ctrl_t;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up_q,
  output logic dn_q
);
  localparam int CW = (RST_DLY < 2) ? 1 : $clog2(RST_DLY);
  localparam logic [CW-1:0] LAST = CW'(RST_DLY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      cnt  <= '0;
    end else if (up_q && dn_q) begin
      if (cnt == LAST) begin
        // Clear overlap; a coincident fresh edge wins over the clear.
        up_q <= ref_rise;
        dn_q <= fb_rise;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (ref_rise) up_q <= 1'b1;
      if (fb_rise)  dn_q <= 1'b1;
      cnt <= '0;
    end
  end
endmodule

// File: rtl/pfd_mode_dec.sv
module pfd_mode_dec
  import pfd_pkg::*;
(
  input  logic [1:0] mode,
  output pfd_ctrl_t  ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (pfd_mode_e'(mode))
      MODE_LO:   ctrl.pump_en = 1'b1;
      MODE_HI: begin
        ctrl.pump_en = 1'b1;
        ctrl.cur_hi  = 1'b1;
      end
      MODE_MID: begin
        ctrl.mon_oe = 1'b1;
        ctrl.mon_fb = 1'b1;
      end
      MODE_OPEN: begin
        ctrl.clamp  = 1'b1;
        ctrl.mon_oe = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl
  import pfd_pkg::*;
#(
  parameter int RST_DLY     = 2,
  parameter int SYNC_STAGES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_div_i,
  input  logic       fb_div_i,
  input  logic [1:0] mode_i,
  output logic       pump_up_o,
  output logic       pump_dn_o,
  output logic       pump_en_o,
  output logic       cur_hi_o,
  output logic       filt_clamp_o,
  output logic       tmon_o,
  output logic       tmon_oe_o
);
  logic      ref_lvl, ref_rise, fb_lvl, fb_rise;
  logic      up_q, dn_q;
  pfd_ctrl_t ctrl;

  pfd_edge_det #(.STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst_n(rst_n), .din(ref_div_i), .lvl(ref_lvl), .rise(ref_rise)
  );

  pfd_edge_det #(.STAGES(SYNC_STAGES)) u_fb_edge (
    .clk(clk), .rst_n(rst_n), .din(fb_div_i), .lvl(fb_lvl), .rise(fb_rise)
  );

  pfd_core #(.RST_DLY(RST_DLY)) u_core (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .up_q(up_q), .dn_q(dn_q)
  );

  pfd_mode_dec u_dec (.mode(mode_i), .ctrl(ctrl));

  assign pump_en_o    = ctrl.pump_en;
  assign cur_hi_o     = ctrl.cur_hi;
  assign filt_clamp_o = ctrl.clamp;
  assign pump_up_o    = up_q & ctrl.pump_en;
  assign pump_dn_o    = dn_q & ctrl.pump_en;
  assign tmon_oe_o    = ctrl.mon_oe;
  assign tmon_o       = ctrl.mon_oe & (ctrl.mon_fb ? fb_lvl : ref_lvl);
endmodule

// File: rtl/pfd_pump_ctrl_chk.sv
module pfd_pump_ctrl_chk #(
  parameter int RST_DLY = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       pump_up_o,
  input logic       pump_dn_o,
  input logic       pump_en_o,
  input logic       cur_hi_o,
  input logic       filt_clamp_o,
  input logic       tmon_o,
  input logic       tmon_oe_o,
  input logic       up_q,
  input logic       dn_q,
  input logic       ref_rise
);
  logic [31:0] both_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              both_cnt <= '0;
    else if (up_q && dn_q)   both_cnt <= both_cnt + 1;
    else                     both_cnt <= '0;
  end

  a_r4_overlap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    both_cnt <= RST_DLY);

  a_r2_up_from_ref_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(ref_rise));

  a_r7_mid_pump_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |-> (!pump_up_o && !pump_dn_o && !pump_en_o && tmon_oe_o));

  a_r8_clamp_pump_off: assert property (@(posedge clk) disable iff (!rst_n)
    filt_clamp_o |-> (!pump_en_o && !pump_up_o && !pump_dn_o));

  a_r9_mon_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[0] == 1'b0) |-> (!tmon_oe_o && !tmon_o && !filt_clamp_o));

  a_r6_cur_needs_pump: assert property (@(posedge clk) disable iff (!rst_n)
    cur_hi_o |-> pump_en_o);
endmodule

bind pfd_pump_ctrl pfd_pump_ctrl_chk #(.RST_DLY(RST_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
  .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .pump_en_o(pump_en_o),
  .cur_hi_o(cur_hi_o), .filt_clamp_o(filt_clamp_o), .tmon_o(tmon_o),
  .tmon_oe_o(tmon_oe_o), .up_q(up_q), .dn_q(dn_q), .ref_rise(ref_rise)
);

// File: tb/pfd_pump_ctrl_bench.sv
module pfd_pump_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_div = 1'b0, fb_div = 1'b0;
  logic [1:0] mode = 2'b00;
  logic up, dn, en, hi, cl, tm, oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [6:0] v;   // {up, dn, en, hi, cl, tm, oe}
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  pfd_pump_ctrl u_pfd_pump_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_div_i(ref_div), .fb_div_i(fb_div),
    .mode_i(mode), .pump_up_o(up), .pump_dn_o(dn), .pump_en_o(en),
    .cur_hi_o(hi), .filt_clamp_o(cl), .tmon_o(tm), .tmon_oe_o(oe)
  );

  task automatic check(input logic [6:0] act, input logic [6:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (up dn en hi cl tm oe)", tag, act, expv);
    end
  endtask

  // Drive at negedge; expectation applies to the sample after the next posedge.
  task automatic cyc(input logic r, input logic f, input logic [1:0] m,
                     input logic eu, input logic ed, input logic etm, input string tag);
    exp_t e;
    logic pen, phi, pcl, poe;
    @(negedge clk);
    ref_div = r; fb_div = f; mode = m;
    pen = (m == 2'b00) || (m == 2'b10);   // R6
    phi = (m == 2'b10);                   // R6
    pcl = (m == 2'b11);                   // R8, R9
    poe = m[0];                           // R7, R8, R9
    e.v = {eu, ed, pen, phi, pcl, etm, poe};
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({up, dn, en, hi, cl, tm, oe}, e.v, e.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    check({up, dn, tm}, 3'b000, "R1 reset");
    @(negedge clk); rst_n = 1'b1;

    // R2 then R3 overlap and R4 clear
    cyc(0,0,2'b00, 0,0,0, "R1 idle");
    cyc(1,0,2'b00, 0,0,0, "R2 latency");
    cyc(1,0,2'b00, 1,0,0, "R2 up");
    cyc(1,0,2'b00, 1,0,0, "R2 up held");
    cyc(0,1,2'b00, 1,0,0, "R3 latency");
    cyc(0,1,2'b00, 1,1,0, "R4 overlap 1");
    cyc(0,1,2'b00, 1,1,0, "R4 overlap 2");
    cyc(0,1,2'b00, 0,0,0, "R4 cleared");
    cyc(0,1,2'b00, 0,0,0, "R11 level held");
    cyc(0,0,2'b00, 0,0,0, "R11 idle");
    // R3 feedback leads
    cyc(0,1,2'b10, 0,0,0, "R3 latency hi");
    cyc(0,1,2'b10, 0,1,0, "R3 dn");
    cyc(0,1,2'b10, 0,1,0, "R3 dn held");
    cyc(1,1,2'b10, 0,1,0, "R3 ref latency");
    cyc(1,1,2'b10, 1,1,0, "R4 overlap a");
    cyc(1,1,2'b10, 1,1,0, "R4 overlap b");
    cyc(0,0,2'b10, 0,0,0, "R4 cleared b");
    cyc(0,0,2'b00, 0,0,0, "R11 idle b");
    // R5 edge in clearing cycle
    cyc(1,1,2'b00, 0,0,0, "R5 setup");
    cyc(0,1,2'b00, 1,1,0, "R5 overlap 1");
    cyc(1,1,2'b00, 1,1,0, "R5 overlap 2");
    cyc(1,0,2'b00, 1,0,0, "R5 up kept");
    cyc(1,1,2'b00, 1,0,0, "R5 up held");
    cyc(1,1,2'b00, 1,1,0, "R5 dn joins");
    cyc(1,1,2'b00, 1,1,0, "R5 overlap");
    cyc(0,0,2'b00, 0,0,0, "R5 cleared");
    cyc(0,0,2'b00, 0,0,0, "R5 idle");
    // R7 mid mode, R10 state runs while off
    cyc(0,1,2'b01, 0,0,1, "R7 mon fb");
    cyc(0,1,2'b01, 0,0,1, "R7 forced off");
    cyc(0,0,2'b01, 0,0,0, "R7 mon fb low");
    cyc(0,0,2'b00, 0,1,0, "R10 dn appears");
    cyc(1,0,2'b00, 0,1,0, "R10 ref latency");
    cyc(1,0,2'b00, 1,1,0, "R10 overlap 1");
    cyc(1,0,2'b00, 1,1,0, "R10 overlap 2");
    cyc(0,0,2'b00, 0,0,0, "R10 cleared");
    // R8 open mode
    cyc(0,0,2'b11, 0,0,0, "R8 mon ref low");
    cyc(1,0,2'b11, 0,0,1, "R8 mon ref high");
    cyc(1,0,2'b11, 0,0,1, "R8 forced off");
    cyc(1,1,2'b00, 1,0,0, "R10 up appears");
    cyc(1,1,2'b00, 1,1,0, "R10 overlap c");
    cyc(1,1,2'b00, 1,1,0, "R10 overlap d");
    cyc(1,1,2'b10, 0,0,0, "R9 cleared hi");
    cyc(0,0,2'b10, 0,0,0, "R9 mon idle hi");
    cyc(0,0,2'b00, 0,0,0, "R9 mon idle lo");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule